// File: doc/BRIEF.md
# NAND Flash Command Sequencer

The sequencer runs one NAND bus operation each time software writes the control register with its start bit set. An operation is a chain of optional phases, each switched on by a flag in the control word. The phases always run in the same order: a first command byte, the column address bytes, the row address bytes, a second command byte, and a data transfer of one to four bytes in either direction. After the second command the engine waits a programmed number of cycles and then waits for the ready/busy pin before it moves on. The start bit stays set while the operation runs, so software polls it to detect the end.

Pulse widths come from a timing register that packs five cycle counts. The number of address bytes comes from a geometry register. A 32-bit data register holds the bytes to write and collects the bytes read, packed little-endian. A chip-select hold flag keeps the chip enable low after the operation ends. With it, software can split one NAND transaction over several control writes, for example one word-sized read per control write, with the hold flag cleared on the last of them.

Top module: `nand_seq_top`

## Requirements
- R1: After reset, ceN, weN and reN are high, cle and ale are low, dqOe is low, and every register reads zero except control bit 26, which reflects rbN.
- R2: The enabled phases run in this order: command 0 (bit 16), column (bit 17), row (bit 18), command 1 (bit 19), data (bit 20 read, bit 21 write). Phases that are not enabled are skipped. Every operation starts with one launch cycle and ends with one finish cycle, and in both of them the strobes are idle.
- R3: The column phase sends geometry bits [5:4]+1 bytes from the column register (address 1), least significant byte first. The row phase sends geometry bits [7:6]+1 bytes from the row register (address 2) in the same way. ale is high for every cycle of each address byte.
- R4: Each command, address or data byte takes four steps, in this order: setup for timing[17:12] cycles, strobe low for timing[5:0], strobe high for timing[11:6], hold for timing[23:18]. A count of zero lasts one cycle. cle is high for every cycle of a command byte. Command 0 comes from control[7:0] and command 1 from control[15:8].
- R5: After the command 1 byte, the engine idles for timing[29:24] cycles (at least one). It then stays idle until rbN is high. Control bit 26 always equals rbN.
- R6: A read phase moves control[29:28]+1 bytes. reN is low during each strobe-low step. dqIn is captured on the last cycle of that step, and byte k goes to data register bits [8k+7:8k]. The data register is cleared when a start with the read flag set is accepted.
- R7: A write phase sends data register bytes least significant first. A command, address or write-data byte drives dqOut, with dqOe high, only while weN is low.
- R8: Control bit 31 reads 1 from the cycle after an accepted start until the operation ends. A start is accepted only when bit 31 of the write is set.
- R9: ceN is low during an operation. When the operation ends, ceN becomes the inverse of control bit 30.
- R10: A start with both read and write set raises control bit 27 and produces no strobe activity. The next start sets bit 27 to whether that start also has both read and write set.
- R11: While an operation runs, writes to any register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register index: 0 control, 1 column, 2 row, 3 data, 4 geometry, 5 timing |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data of the selected register |
| ceN | output | 1 | Chip enable, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| weN | output | 1 | Write strobe, active low |
| reN | output | 1 | Read strobe, active low |
| dqOut | output | 8 | Data bus output value |
| dqOe | output | 1 | Data bus output enable |
| dqIn | input | 8 | Data bus input value |
| rbN | input | 1 | Ready/busy from the flash, high when ready |

## Verification
The assertions assume that rbN, dqIn and the register inputs are synchronous to clk and never change near a rising edge. They also assume that reset is held long enough for the first compare to see reset values. On those terms they check that the strobes stay idle whenever no operation runs, that command and address latch enables never overlap, and that read and write strobes are never low together. The bench changes every input one time unit after the rising edge. It holds rbN low only while an operation is at or before its wait step, and it programs only timing counts that fit their six-bit fields.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [2:0] {
    PH_NONE = 3'd0,
    PH_CMD0 = 3'd1,
    PH_COL  = 3'd2,
    PH_ROW  = 3'd3,
    PH_CMD1 = 3'd4,
    PH_DATA = 3'd5
  } phaseT;

  // strobes from control to datapath
  typedef struct packed {
    phaseT      phase;
    logic [1:0] byteIdx;
    logic       inCycle;
    logic       strobeLow;
    logic       latchRd;
    logic       opDone;
  } strobeT;

  // decoded register state from datapath to control
  typedef struct packed {
    logic [4:0] phaseEn;   // [0] cmd0 [1] col [2] row [3] cmd1 [4] data
    logic       badCombo;
    logic [1:0] colLast;
    logic [1:0] rowLast;
    logic [1:0] dataLast;
    logic       startPulse;
  } opCfgT;

endpackage

// File: rtl/nand_seq_ctrl.sv
module nand_seq_ctrl
  import nand_seq_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  opCfgT              cfg,
  input  logic [5*CNT_W-1:0] waitCnt,
  input  logic               rbN,
  output strobeT             stb
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_LAUNCH, ST_SETUP, ST_LOW, ST_HIGH, ST_HOLD, ST_WAIT, ST_FIN
  } stateT;

  logic [CNT_W-1:0] wLow, wHigh, wSetup, wHold, wBusy;
  assign wLow   = waitCnt[0*CNT_W +: CNT_W];
  assign wHigh  = waitCnt[1*CNT_W +: CNT_W];
  assign wSetup = waitCnt[2*CNT_W +: CNT_W];
  assign wHold  = waitCnt[3*CNT_W +: CNT_W];
  assign wBusy  = waitCnt[4*CNT_W +: CNT_W];

  stateT st, stNx;
  phaseT ph, phNx, advPh;
  logic [1:0] idx, idxNx, lastIdx;
  logic [CNT_W-1:0] cnt, cntNx;
  logic advance;

  // a zero count still lasts one cycle
  function automatic logic [CNT_W-1:0] span(input logic [CNT_W-1:0] w);
    return (w == '0) ? '0 : w - 1'b1;
  endfunction

  function automatic phaseT nextEnabled(input phaseT cur, input logic [4:0] en);
    phaseT r;
    r = PH_NONE;
    for (int p = 5; p >= 1; p--)
      if (p > int'(cur) && en[p-1]) r = phaseT'(3'(p));
    return r;
  endfunction

  always_comb begin
    case (ph)
      PH_COL:  lastIdx = cfg.colLast;
      PH_ROW:  lastIdx = cfg.rowLast;
      PH_DATA: lastIdx = cfg.dataLast;
      default: lastIdx = 2'd0;
    endcase
  end

  assign advPh = nextEnabled((st == ST_LAUNCH) ? PH_NONE : ph, cfg.phaseEn);

  always_comb begin
    stNx    = st;
    phNx    = ph;
    idxNx   = idx;
    cntNx   = (cnt != '0) ? cnt - 1'b1 : cnt;
    advance = 1'b0;
    case (st)
      ST_IDLE:   if (cfg.startPulse) begin stNx = ST_LAUNCH; cntNx = '0; end
      ST_LAUNCH: if (cfg.badCombo) stNx = ST_FIN; else advance = 1'b1;
      ST_SETUP:  if (cnt == '0) begin stNx = ST_LOW;  cntNx = span(wLow);  end
      ST_LOW:    if (cnt == '0) begin stNx = ST_HIGH; cntNx = span(wHigh); end
      ST_HIGH:   if (cnt == '0) begin stNx = ST_HOLD; cntNx = span(wHold); end
      ST_HOLD: begin
        if (cnt == '0) begin
          if (idx != lastIdx) begin
            stNx = ST_SETUP; idxNx = idx + 2'd1; cntNx = span(wSetup);
          end else if (ph == PH_CMD1) begin
            stNx = ST_WAIT; cntNx = span(wBusy);
          end else begin
            advance = 1'b1;
          end
        end
      end
      ST_WAIT:   if (cnt == '0 && rbN) advance = 1'b1;
      ST_FIN:    begin stNx = ST_IDLE; phNx = PH_NONE; end
      default:   stNx = ST_IDLE;
    endcase
    if (advance) begin
      if (advPh == PH_NONE) begin
        stNx = ST_FIN;
      end else begin
        stNx = ST_SETUP; phNx = advPh; idxNx = 2'd0; cntNx = span(wSetup);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st  <= ST_IDLE;
      ph  <= PH_NONE;
      idx <= 2'd0;
      cnt <= '0;
    end else begin
      st  <= stNx;
      ph  <= phNx;
      idx <= idxNx;
      cnt <= cntNx;
    end
  end

  assign stb.phase     = ph;
  assign stb.byteIdx   = idx;
  assign stb.inCycle   = (st == ST_SETUP) || (st == ST_LOW) || (st == ST_HIGH) || (st == ST_HOLD);
  assign stb.strobeLow = (st == ST_LOW);
  assign stb.latchRd   = (st == ST_LOW) && (cnt == '0) && (ph == PH_DATA);
  assign stb.opDone    = (st == ST_FIN);

endmodule

// File: rtl/nand_seq_dp.sv
module nand_seq_dp
  import nand_seq_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int ADDR_W = 3,
  parameter int REG_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWe,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [REG_W-1:0]   regWrData,
  output logic [REG_W-1:0]   regRdData,
  input  strobeT             stb,
  output opCfgT              cfg,
  output logic [5*CNT_W-1:0] waitCnt,
  output logic               busy,
  output logic               ceN,
  output logic               cle,
  output logic               ale,
  output logic               weN,
  output logic               reN,
  output logic [7:0]         dqOut,
  output logic               dqOe,
  input  logic [7:0]         dqIn
);

  localparam int WAIT_W = 5 * CNT_W;
  localparam logic [ADDR_W-1:0] RA_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] RA_COL  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] RA_ROW  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] RA_DATA = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] RA_GEOM = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] RA_TIME = ADDR_W'(5);

  logic [7:0]        cmdFirst, cmdSecond;
  logic [5:0]        flags;
  logic [1:0]        xferLast, colLast, rowLast;
  logic              holdCs, startBit, errBit;
  logic [REG_W-1:0]  colReg, rowReg, dataReg;
  logic [WAIT_W-1:0] timeReg;
  logic              wrOk, startPulse, rdFlag, wrFlag;

  assign rdFlag     = flags[4];
  assign wrFlag     = flags[5];
  assign wrOk       = regWe && !startBit;
  assign startPulse = wrOk && (regAddr == RA_CTRL) && regWrData[31];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdFirst <= '0; cmdSecond <= '0; flags <= '0; xferLast <= '0; holdCs <= 1'b0;
      colReg <= '0; rowReg <= '0; dataReg <= '0; colLast <= '0; rowLast <= '0;
      timeReg <= '0; startBit <= 1'b0; errBit <= 1'b0;
    end else begin
      if (wrOk) begin
        case (regAddr)
          RA_CTRL: begin
            cmdFirst  <= regWrData[7:0];
            cmdSecond <= regWrData[15:8];
            flags     <= regWrData[21:16];
            xferLast  <= regWrData[29:28];
            holdCs    <= regWrData[30];
          end
          RA_COL:  colReg  <= regWrData;
          RA_ROW:  rowReg  <= regWrData;
          RA_DATA: dataReg <= regWrData;
          RA_GEOM: {rowLast, colLast} <= regWrData[7:4];
          RA_TIME: timeReg <= regWrData[WAIT_W-1:0];
          default: ;
        endcase
      end
      if (startPulse) begin
        startBit <= 1'b1;
        errBit   <= regWrData[20] & regWrData[21];
        if (regWrData[20]) dataReg <= '0;
      end else if (stb.opDone) begin
        startBit <= 1'b0;
      end
      if (stb.latchRd && rdFlag) dataReg[{stb.byteIdx, 3'b000} +: 8] <= dqIn;
    end
  end

  assign cfg.phaseEn    = {rdFlag | wrFlag, flags[3:0]};
  assign cfg.badCombo   = rdFlag & wrFlag;
  assign cfg.colLast    = colLast;
  assign cfg.rowLast    = rowLast;
  assign cfg.dataLast   = xferLast;
  assign cfg.startPulse = startPulse;
  assign waitCnt        = timeReg;
  assign busy           = startBit;

  logic isCmd, isAddr, rdXfer;
  assign isCmd  = (stb.phase == PH_CMD0) || (stb.phase == PH_CMD1);
  assign isAddr = (stb.phase == PH_COL)  || (stb.phase == PH_ROW);
  assign rdXfer = (stb.phase == PH_DATA) && rdFlag;

  assign ceN  = !(startBit || holdCs);
  assign cle  = stb.inCycle && isCmd;
  assign ale  = stb.inCycle && isAddr;
  assign weN  = !(stb.strobeLow && !rdXfer);
  assign reN  = !(stb.strobeLow && rdXfer);
  assign dqOe = stb.strobeLow && !rdXfer;

  always_comb begin
    case (stb.phase)
      PH_CMD0: dqOut = cmdFirst;
      PH_CMD1: dqOut = cmdSecond;
      PH_COL:  dqOut = colReg[{stb.byteIdx, 3'b000} +: 8];
      PH_ROW:  dqOut = rowReg[{stb.byteIdx, 3'b000} +: 8];
      PH_DATA: dqOut = dataReg[{stb.byteIdx, 3'b000} +: 8];
      default: dqOut = 8'h00;
    endcase
  end

  always_comb begin
    case (regAddr)
      RA_CTRL: regRdData = {startBit, holdCs, xferLast, errBit, 1'b0, 4'b0000,
                            flags, cmdSecond, cmdFirst};
      RA_COL:  regRdData = colReg;
      RA_ROW:  regRdData = rowReg;
      RA_DATA: regRdData = dataReg;
      RA_GEOM: regRdData = {{(REG_W-8){1'b0}}, rowLast, colLast, 4'b0000};
      RA_TIME: regRdData = {{(REG_W-WAIT_W){1'b0}}, timeReg};
      default: regRdData = '0;
    endcase
  end

endmodule

// File: rtl/nand_seq_top.sv
module nand_seq_top
  import nand_seq_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int ADDR_W = 3,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  output logic              ceN,
  output logic              cle,
  output logic              ale,
  output logic              weN,
  output logic              reN,
  output logic [7:0]        dqOut,
  output logic              dqOe,
  input  logic [7:0]        dqIn,
  input  logic              rbN
);

  strobeT             stb;
  opCfgT              cfg;
  logic [5*CNT_W-1:0] waitCnt;
  logic               busy;
  logic [REG_W-1:0]   dpRdData;

  // ready bit mirrors the pin directly
  assign regRdData = (regAddr == ADDR_W'(0)) ? (dpRdData | (REG_W'(rbN) << 26)) : dpRdData;

  nand_seq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfg(cfg), .waitCnt(waitCnt), .rbN(rbN), .stb(stb)
  );

  nand_seq_dp #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .REG_W(REG_W)) u_dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(dpRdData), .stb(stb), .cfg(cfg), .waitCnt(waitCnt), .busy(busy),
    .ceN(ceN), .cle(cle), .ale(ale), .weN(weN), .reN(reN), .dqOut(dqOut),
    .dqOe(dqOe), .dqIn(dqIn)
  );

endmodule

// File: rtl/nand_seq_checks.sv
module nand_seq_checks (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic ceN,
  input logic cle,
  input logic ale,
  input logic weN,
  input logic reN,
  input logic dqOe
);

  assert_latch_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(cle && ale));

  assert_drive_window_R7: assert property (@(posedge clk) disable iff (!rstN)
    dqOe |-> !weN);

  assert_single_strobe_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(!weN && !reN));

  assert_quiet_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (weN && reN && !cle && !ale && !dqOe));

  assert_ce_active_R9: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !ceN);

  assert_finish_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(weN && reN && !cle && !ale));

endmodule

bind nand_seq_top nand_seq_checks u_checks (
  .clk(clk), .rstN(rstN), .busy(busy), .ceN(ceN), .cle(cle), .ale(ale),
  .weN(weN), .reN(reN), .dqOe(dqOe)
);

// File: tb/tb_nand_seq_top.sv
module tb_nand_seq_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [31:0] regWrData = 32'd0;
  logic [31:0] regRdData;
  logic        ceN, cle, ale, weN, reN, dqOe;
  logic [7:0]  dqOut;
  logic [7:0]  dqIn = 8'h3C;
  logic        rbN = 1'b1;

  always #4 clk = ~clk;   // 125 MHz

  nand_seq_top dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .ceN(ceN), .cle(cle), .ale(ale), .weN(weN), .reN(reN),
    .dqOut(dqOut), .dqOe(dqOe), .dqIn(dqIn), .rbN(rbN)
  );

  typedef struct {
    bit cle; bit ale; bit weN; bit reN; bit oe; bit gate; bit latch;
    logic [7:0] dq; int idx;
  } entT;

  entT q[$];
  logic [7:0]  mCmd0 = 0, mCmd1 = 0;
  logic [5:0]  mFlags = 0;
  logic [1:0]  mNb = 0, mRowL = 0, mColL = 0;
  logic        mHold = 0, mErr = 0;
  logic [31:0] mCol = 0, mRow = 0, mData = 0;
  logic [29:0] mWait = 0;
  logic [2:0]  rdSel = 3'd0;
  string       curReq = "R1";
  int          nCmp = 0, nBad = 0, cyc = 0;

  function automatic int m(input logic [5:0] w);
    return (w == 0) ? 1 : int'(w);
  endfunction

  function automatic void pushN(int n, bit c, bit a, bit we, bit re, bit oe,
                                logic [7:0] d, bit gateLast, bit latchLast, int idx);
    for (int i = 0; i < n; i++) begin
      entT e;
      e.cle = c; e.ale = a; e.weN = we; e.reN = re; e.oe = oe; e.dq = d; e.idx = idx;
      e.gate = gateLast && (i == n - 1);
      e.latch = latchLast && (i == n - 1);
      q.push_back(e);
    end
  endfunction

  function automatic void pushByte(bit c, bit a, bit rd, logic [7:0] d, int idx);
    pushN(m(mWait[17:12]), c, a, 1, 1, 0, d, 0, 0, idx);
    pushN(m(mWait[5:0]),   c, a, rd, !rd, !rd, d, 0, rd, idx);
    pushN(m(mWait[11:6]),  c, a, 1, 1, 0, d, 0, 0, idx);
    pushN(m(mWait[23:18]), c, a, 1, 1, 0, d, 0, 0, idx);
  endfunction

  function automatic void buildOp();
    pushN(1, 0, 0, 1, 1, 0, 8'h00, 0, 0, 0);            // launch
    if (!(mFlags[4] && mFlags[5])) begin
      if (mFlags[0]) pushByte(1, 0, 0, mCmd0, 0);
      if (mFlags[1]) for (int i = 0; i <= int'(mColL); i++) pushByte(0, 1, 0, mCol[8*i +: 8], i);
      if (mFlags[2]) for (int i = 0; i <= int'(mRowL); i++) pushByte(0, 1, 0, mRow[8*i +: 8], i);
      if (mFlags[3]) begin
        pushByte(1, 0, 0, mCmd1, 0);
        pushN(m(mWait[29:24]), 0, 0, 1, 1, 0, 8'h00, 1, 0, 0);
      end
      if (mFlags[4]) for (int i = 0; i <= int'(mNb); i++) pushByte(0, 0, 1, 8'h00, i);
      if (mFlags[5]) for (int i = 0; i <= int'(mNb); i++) pushByte(0, 0, 0, mData[8*i +: 8], i);
    end
    pushN(1, 0, 0, 1, 1, 0, 8'h00, 0, 0, 0);            // finish
  endfunction

  function automatic logic [31:0] expRead(input logic [2:0] a);
    case (a)
      3'd0: return {q.size() != 0, mHold, mNb, mErr, rbN, 4'b0000, mFlags, mCmd1, mCmd0};
      3'd1: return mCol;
      3'd2: return mRow;
      3'd3: return mData;
      3'd4: return {24'd0, mRowL, mColL, 4'b0000};
      3'd5: return {2'b00, mWait};
      default: return 32'd0;
    endcase
  endfunction

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  // reference model, advanced on each rising edge
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nBad++;
      $display("FAIL watchdog %s: actual running expected finished", curReq);
      finishRun();
    end
    if (!rstN) begin
      q.delete();
      mCmd0 = 0; mCmd1 = 0; mFlags = 0; mNb = 0; mRowL = 0; mColL = 0;
      mHold = 0; mErr = 0; mCol = 0; mRow = 0; mData = 0; mWait = 0;
    end else if (q.size() != 0) begin
      entT e;
      e = q[0];
      if (!(e.gate && !rbN)) begin
        void'(q.pop_front());
        if (e.latch) mData[8*e.idx +: 8] = dqIn;
      end
    end else if (regWe) begin
      case (regAddr)
        3'd0: begin
          mCmd0 = regWrData[7:0]; mCmd1 = regWrData[15:8]; mFlags = regWrData[21:16];
          mNb = regWrData[29:28]; mHold = regWrData[30];
          if (regWrData[31]) begin
            mErr = regWrData[20] & regWrData[21];
            if (regWrData[20]) mData = 0;
            buildOp();
          end
        end
        3'd1: mCol = regWrData;
        3'd2: mRow = regWrData;
        3'd3: mData = regWrData;
        3'd4: {mRowL, mColL} = regWrData[7:4];
        3'd5: mWait = regWrData[29:0];
        default: ;
      endcase
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (cyc >= 2) begin
      logic [5:0]  expPins, actPins;
      logic [7:0]  expDq;
      logic [31:0] expRd;
      if (q.size() != 0) begin
        expPins = {1'b0, q[0].cle, q[0].ale, q[0].weN, q[0].reN, q[0].oe};
        expDq = q[0].dq;
      end else begin
        expPins = {!mHold, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
        expDq = 8'h00;
      end
      actPins = {ceN, cle, ale, weN, reN, dqOe};
      expRd = expRead(regAddr);
      nCmp++;
      if (actPins !== expPins || (expPins[0] && dqOut !== expDq) || regRdData !== expRd) begin
        nBad++;
        $display("FAIL %s cyc %0d: pins %b dq %h rd %h expected pins %b dq %h rd %h",
                 curReq, cyc, actPins, dqOut, regRdData, expPins, expDq, expRd);
      end
    end
  end

  // read-data stimulus changes every cycle
  always @(posedge clk) begin
    #1;
    dqIn = dqIn + 8'h27;
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    regWe = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    regWe = 1'b0; regAddr = rdSel;
  endtask

  task automatic watch(input logic [2:0] a);
    @(posedge clk); #1;
    rdSel = a; regAddr = a;
  endtask

  task automatic waitIdle();
    do begin @(posedge clk); #1; end while (q.size() != 0);
    repeat (3) @(posedge clk);
  endtask

  task automatic rbPulse(input int dly, input int len);
    repeat (dly) @(posedge clk);
    #1 rbN = 1'b0;
    repeat (len) @(posedge clk);
    #1 rbN = 1'b1;
  endtask

  initial begin
    curReq = "R1";                        // reset state
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    repeat (3) @(posedge clk);

    curReq = "R4";                        // step widths, zero hold treated as one
    wr(3'd5, {2'b00, 6'd4, 6'd0, 6'd3, 6'd1, 6'd2});
    wr(3'd4, 32'h0000_0090);              // col 2 bytes, row 3 bytes
    wr(3'd0, 32'h8001_00FF);              // command 0 only, no hold
    waitIdle();

    curReq = "R3";                        // address bytes LSB first, with hold
    wr(3'd1, 32'h0000_5A34);
    wr(3'd2, 32'h0012_3456);
    wr(3'd0, 32'hC007_0080);
    waitIdle();

    curReq = "R9";                        // chip enable held after operation
    repeat (5) @(posedge clk);

    curReq = "R5";                        // wait after command 1 for ready
    wr(3'd0, 32'hC008_3000);
    rbPulse(2, 20);
    waitIdle();

    curReq = "R6";                        // four-byte read, then one byte clears upper
    watch(3'd3);
    wr(3'd0, 32'hB010_0000);
    waitIdle();
    wr(3'd0, 32'h8010_0000);
    waitIdle();

    curReq = "R2";                        // full chain in fixed order
    watch(3'd0);
    wr(3'd0, 32'h901F_3000);
    rbPulse(3, 15);
    waitIdle();

    curReq = "R7";                        // write three bytes, column only before
    wr(3'd3, 32'h4433_2211);
    wr(3'd0, 32'hA022_0000);
    waitIdle();

    curReq = "R10";                       // read and write together flag error
    wr(3'd0, 32'h8030_0000);
    waitIdle();
    wr(3'd0, 32'h8001_0070);
    waitIdle();

    curReq = "R11";                       // writes ignored while running
    wr(3'd5, {2'b00, 6'd2, 6'd2, 6'd20, 6'd20, 6'd20});
    wr(3'd0, 32'h8001_00AA);
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd3, 32'hDEAD_BEEF);
    wr(3'd0, 32'hC02F_0101);
    waitIdle();
    watch(3'd1);
    repeat (2) @(posedge clk);
    watch(3'd0);

    curReq = "R8";                        // zero timing and empty operation
    wr(3'd5, 32'h0000_0000);
    wr(3'd0, 32'h8001_0090);
    waitIdle();
    wr(3'd0, 32'h8000_0000);
    waitIdle();

    finishRun();
  end

endmodule